// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block derives the oversampling enable for a serial receiver/transmitter pair from a reference clock. A 16-bit integer divisor is presented as a high byte and a low byte. A 4-bit fraction counts sixteenths of one reference cycle. An oversampling select sets 16, 8 or 4 sample ticks per bit. The block produces two one-cycle strobes. `sample_tick` marks the end of each sample period. `bit_tick` marks every N-th sample tick, where N is the selected ratio.

The fraction is handled by dithering. A 4-bit phase accumulator adds the fraction once per sample period. Each carry out of the accumulator stretches the next period by one reference cycle. So in every run of sixteen sample periods, exactly F of them are D+1 cycles long, and they are spread as evenly as the accumulator allows. The average sample period is therefore D + F/16 cycles, and the bit rate is f_ref / (N × (D + F/16)).

The divisor and mode inputs are captured only on a one-cycle load strobe. A new setting waits until the current sample period ends, so no period is ever cut short. When the block is idle, the setting starts at once. A divisor of zero stops both strobes.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset and before the first load strobe, neither `sample_tick` nor `bit_tick` is ever asserted, whatever values the divisor inputs carry.
- R2: Changes on `div_hi`, `div_lo`, `frac_in` and `osr_sel` have no effect unless `cfg_load` is high in that cycle; the tick pattern keeps the previously loaded setting.
- R3: Number the sample periods after a setting takes effect as i = 1, 2, …. Period i lasts D + (⌊i·F/16⌋ − ⌊(i−1)·F/16⌋) reference cycles, where D = {div_hi, div_lo} and F = frac_in. So the first period is exactly D cycles, because the phase accumulator restarts from zero.
- R4: Any 16 consecutive sample periods together last exactly 16·D + F reference cycles.
- R5: Every sample period lasts D or D+1 cycles. When F ≤ 8, no two consecutive periods are stretched.
- R6: `osr_sel` encoding: 2'b00 gives N=16, 2'b01 gives N=8, 2'b10 gives N=4, 2'b11 gives N=16. `bit_tick` is asserted only together with `sample_tick`, on every N-th sample tick.
- R7: With a loaded divisor of zero, neither strobe is asserted.
- R8: A load while ticks are running takes effect at the end of the sample period in progress; that period keeps its old length.
- R9: A load while idle takes effect at once. The first `sample_tick` is asserted in the D-th cycle after the cycle in which `cfg_load` is high.
- R10: The sample count restarts when a setting takes effect. The first `bit_tick` comes on the N-th sample tick after that point.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | One-cycle strobe that captures the divisor, fraction and mode inputs |
| div_hi | input | 8 | Upper byte of the integer divisor |
| div_lo | input | 8 | Lower byte of the integer divisor |
| frac_in | input | 4 | Fractional part of the divisor, in sixteenths |
| osr_sel | input | 2 | Oversampling ratio select (see R6) |
| sample_tick | output | 1 | One-cycle strobe at the end of each sample period |
| bit_tick | output | 1 | One-cycle strobe on every N-th sample tick |

## Verification
The hardest case to reach is a reload that lands in the middle of a long period while the accumulator holds a non-zero phase. The old period must finish at full length. The new sequence must then restart both the dither phase and the sample count. The bench runs a 100-cycle divisor and strobes the load ten cycles into a period. It then checks that the period still closes at 100 cycles, followed by a 3-cycle period and then a 4-cycle period (fraction 15). It also checks that the first bit strobe falls on the sixteenth new sample. A loop over a vector table places its measurement window a full bit after each reload. This way the predicted period sequence of R3 is tested at an arbitrary accumulator phase, not only from phase zero.

// File: rtl/fbg_pkg.sv
package fbg_pkg;

  // Oversampling select codes.
  typedef enum logic [1:0] {
    OSR_X16     = 2'b00,
    OSR_X8      = 2'b01,
    OSR_X4      = 2'b10,
    OSR_X16_ALT = 2'b11
  } osr_sel_e;

  localparam int unsigned OSR_MAX   = 16;
  localparam int unsigned OSR_CNT_W = $clog2(OSR_MAX);

  // Index of the last sample tick in a bit, i.e. ratio - 1.
  function automatic logic [OSR_CNT_W-1:0] osr_last(input logic [1:0] sel);
    logic [OSR_CNT_W-1:0] r;
    case (sel)
      OSR_X8:  r = OSR_CNT_W'(7);
      OSR_X4:  r = OSR_CNT_W'(3);
      default: r = OSR_CNT_W'(OSR_MAX - 1);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/fbg_cfg_stage.sv
module fbg_cfg_stage #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned FRAC_W = 4,
  localparam int unsigned DIV_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] hi_i,
  input  logic [BYTE_W-1:0] lo_i,
  input  logic [FRAC_W-1:0] frac_i,
  input  logic [1:0]        sel_i,
  input  logic              boundary_i,
  output logic              apply_o,
  output logic [DIV_W-1:0]  nxt_div_o,
  output logic [FRAC_W-1:0] nxt_frac_o,
  output logic [1:0]        nxt_sel_o,
  output logic [DIV_W-1:0]  act_div_o,
  output logic [FRAC_W-1:0] act_frac_o,
  output logic [1:0]        act_sel_o
);

  logic              pend_q;
  logic [DIV_W-1:0]  stg_div_q, act_div_q;
  logic [FRAC_W-1:0] stg_frac_q, act_frac_q;
  logic [1:0]        stg_sel_q, act_sel_q;
  logic              running;
  logic              want;

  assign running = (act_div_q != '0);
  assign want    = load_i | pend_q;
  // A new setting lands at a period end, or at once when idle.
  assign apply_o = want & (boundary_i | ~running);

  assign nxt_div_o  = load_i ? {hi_i, lo_i} : stg_div_q;
  assign nxt_frac_o = load_i ? frac_i       : stg_frac_q;
  assign nxt_sel_o  = load_i ? sel_i        : stg_sel_q;

  assign act_div_o  = act_div_q;
  assign act_frac_o = act_frac_q;
  assign act_sel_o  = act_sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      stg_div_q  <= '0;
      stg_frac_q <= '0;
      stg_sel_q  <= '0;
      act_div_q  <= '0;
      act_frac_q <= '0;
      act_sel_q  <= '0;
    end else begin
      if (load_i) begin
        stg_div_q  <= {hi_i, lo_i};
        stg_frac_q <= frac_i;
        stg_sel_q  <= sel_i;
      end
      pend_q <= want & ~apply_o;
      if (apply_o) begin
        act_div_q  <= nxt_div_o;
        act_frac_q <= nxt_frac_o;
        act_sel_q  <= nxt_sel_o;
      end
    end
  end

  // R2: the live setting changes only through an apply event
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !apply_o |=> ($stable(act_div_q) && $stable(act_frac_q) && $stable(act_sel_q)));

  // R8: a deferred setting stays pending until it is applied
  a_r8_pend_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !apply_o) |=> pend_q);

  // R8: applying consumes the pending setting
  a_r8_apply_clears: assert property (@(posedge clk) disable iff (!rst_n)
    apply_o |=> !pend_q);

endmodule

// File: rtl/fbg_tick_core.sv
module fbg_tick_core #(
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  act_div_i,
  input  logic [FRAC_W-1:0] act_frac_i,
  input  logic              apply_i,
  input  logic [DIV_W-1:0]  nxt_div_i,
  input  logic [FRAC_W-1:0] nxt_frac_i,
  output logic              tick_o
);

  // Phase accumulator step: MSB of the result is the stretch flag.
  function automatic logic [FRAC_W:0] dither_step(
    input logic [FRAC_W-1:0] phase,
    input logic [FRAC_W-1:0] step
  );
    return {1'b0, phase} + {1'b0, step};
  endfunction

  // Down-counter preset for a period of d (+1 when stretched) cycles.
  function automatic logic [DIV_W-1:0] period_preset(
    input logic [DIV_W-1:0] d,
    input logic             stretch
  );
    return d - DIV_W'(1) + DIV_W'(stretch);
  endfunction

  logic [DIV_W-1:0]  cnt_q;
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   step_now;
  logic              running;

  assign running  = (act_div_i != '0);
  assign tick_o   = running && (cnt_q == '0);
  assign step_now = apply_i ? dither_step('0, nxt_frac_i)
                            : dither_step(acc_q, act_frac_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (apply_i) begin
      acc_q <= step_now[FRAC_W-1:0];
      cnt_q <= period_preset(nxt_div_i, step_now[FRAC_W]);
    end else if (tick_o) begin
      acc_q <= step_now[FRAC_W-1:0];
      cnt_q <= period_preset(act_div_i, step_now[FRAC_W]);
    end else if (running) begin
      cnt_q <= cnt_q - DIV_W'(1);
    end
  end

  // R3: each new period is D or D+1 cycles long
  a_r3_preset_range: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && !apply_i) |=>
      ((cnt_q == $past(act_div_i)) || (cnt_q == $past(act_div_i) - DIV_W'(1))));

  // R3: phase restarts from zero on a new setting
  a_r3_restart_phase: assert property (@(posedge clk) disable iff (!rst_n)
    apply_i |=> (acc_q == $past(nxt_frac_i)));

  // R3: the first period of a new setting is never stretched
  a_r3_first_plain: assert property (@(posedge clk) disable iff (!rst_n)
    (apply_i && (nxt_div_i != '0)) |=> (cnt_q == $past(nxt_div_i) - DIV_W'(1)));

  // R7: an idle counter does not move
  a_r7_idle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !apply_i) |=> $stable(cnt_q));

endmodule

// File: rtl/fbg_bit_div.sv
module fbg_bit_div
  import fbg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sample_i,
  input  logic       apply_i,
  input  logic [1:0] sel_i,
  output logic       bit_o
);

  logic [OSR_CNT_W-1:0] sc_q;
  logic                 at_last;

  assign at_last = (sc_q == osr_last(sel_i));
  assign bit_o   = sample_i && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc_q <= '0;
    end else if (apply_i) begin
      sc_q <= '0;
    end else if (sample_i) begin
      sc_q <= at_last ? '0 : sc_q + OSR_CNT_W'(1);
    end
  end

  // R6: a bit strobe always coincides with a sample strobe
  a_r6_bit_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
    bit_o |-> sample_i);

  // R6: the sample count never passes the selected ratio
  a_r6_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
    sc_q <= osr_last(sel_i));

  // R10: the count restarts whenever a setting is applied
  a_r10_restart: assert property (@(posedge clk) disable iff (!rst_n)
    apply_i |=> (sc_q == '0));

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [BYTE_W-1:0] div_hi,
  input  logic [BYTE_W-1:0] div_lo,
  input  logic [FRAC_W-1:0] frac_in,
  input  logic [1:0]        osr_sel,
  output logic              sample_tick,
  output logic              bit_tick
);

  localparam int unsigned DIV_W = 2 * BYTE_W;

  logic              apply;
  logic [DIV_W-1:0]  nxt_div, act_div;
  logic [FRAC_W-1:0] nxt_frac, act_frac;
  logic [1:0]        nxt_sel, act_sel;

  fbg_cfg_stage #(.BYTE_W(BYTE_W), .FRAC_W(FRAC_W)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (cfg_load),
    .hi_i       (div_hi),
    .lo_i       (div_lo),
    .frac_i     (frac_in),
    .sel_i      (osr_sel),
    .boundary_i (sample_tick),
    .apply_o    (apply),
    .nxt_div_o  (nxt_div),
    .nxt_frac_o (nxt_frac),
    .nxt_sel_o  (nxt_sel),
    .act_div_o  (act_div),
    .act_frac_o (act_frac),
    .act_sel_o  (act_sel)
  );

  fbg_tick_core #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .act_div_i  (act_div),
    .act_frac_i (act_frac),
    .apply_i    (apply),
    .nxt_div_i  (nxt_div),
    .nxt_frac_i (nxt_frac),
    .tick_o     (sample_tick)
  );

  fbg_bit_div u_bit (
    .clk      (clk),
    .rst_n    (rst_n),
    .sample_i (sample_tick),
    .apply_i  (apply),
    .sel_i    (act_sel),
    .bit_o    (bit_tick)
  );

  // R7: a zero divisor silences both strobes
  a_r7_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (act_div == '0) |-> (!sample_tick && !bit_tick));

endmodule

// File: tb/sim_frac_baud_gen.sv
`timescale 1ns/1ps
module sim_frac_baud_gen;

  localparam real CLK_NS = 5.0;
  localparam int  WD_CYC = 190000;
  localparam int  NV     = 9;
  // {divisor[15:0], fraction[3:0], osr_sel[1:0]}
  localparam logic [21:0] VEC [NV] = '{
    {16'd13,     4'd0,  2'b00},
    {16'd1,      4'd10, 2'b00},
    {16'd156,    4'd4,  2'b00},
    {16'd6,      4'd11, 2'b01},
    {16'h0EA6,   4'd0,  2'b10},
    {16'd2,      4'd8,  2'b10},
    {16'd1,      4'd0,  2'b00},
    {16'd7,      4'd8,  2'b11},
    {16'd39,     4'd1,  2'b01}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_load = 1'b0;
  logic [7:0] div_hi = 8'd0;
  logic [7:0] div_lo = 8'd7;
  logic [3:0] frac_in = 4'd3;
  logic [1:0] osr_sel = 2'b00;
  logic       sample_tick, bit_tick;

  int checks = 0;
  int fails  = 0;

  frac_baud_gen u0 (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
    .div_hi(div_hi), .div_lo(div_lo), .frac_in(frac_in), .osr_sel(osr_sel),
    .sample_tick(sample_tick), .bit_tick(bit_tick)
  );

  always #(CLK_NS/2) clk = ~clk;

  function automatic int ratio_of(input logic [1:0] m);
    if (m == 2'b01) return 8;
    if (m == 2'b10) return 4;
    return 16;
  endfunction

  function automatic int stretch(input int i, input int f);
    return (i * f) / 16 - ((i - 1) * f) / 16;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Called at a negedge; returns so that the next negedge is the first
  // cycle under the new setting.
  task automatic load_cfg(input int d, input int f, input logic [1:0] m);
    bit pre;
    pre = sample_tick;
    {div_hi, div_lo} = 16'(d);
    frac_in  = 4'(f);
    osr_sel  = m;
    cfg_load = 1'b1;
    @(posedge clk); #1;
    cfg_load = 1'b0;
    if (!pre) begin
      do @(negedge clk); while (!sample_tick);
    end
  endtask

  task automatic measure(input int d, input int f, input int n, input int nper, input bit win);
    int k = 0, len = 0, sum = 0;
    bit prev_ext = 1'b0;
    while (k < nper) begin
      @(negedge clk);
      len++;
      if (sample_tick) begin
        k++;
        check(len == d + stretch(k, f), "R3 period length", len, d + stretch(k, f));
        check((len == d) || (len == d + 1), "R5 period range", len, d);
        if (f <= 8) begin
          check(!(prev_ext && len == d + 1), "R5 consecutive stretch", len, d);
        end
        prev_ext = (len == d + 1);
        check(bit_tick == ((k % n) == 0), "R6 R10 bit strobe", int'(bit_tick), int'((k % n) == 0));
        if (win && k > n && k <= n + 16) sum += len;
        len = 0;
      end else if (bit_tick) begin
        check(1'b0, "R6 bit without sample", 1, 0);
      end
    end
    if (win) check(sum == 16 * d + f, "R4 sixteen-period total", sum, 16 * d + f);
  endtask

  initial begin
    #(WD_CYC * CLK_NS);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", WD_CYC);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int seen;
    int fb;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1: no strobes before any load, despite non-zero inputs
    seen = 0;
    repeat (100) begin
      @(negedge clk);
      if (sample_tick || bit_tick) seen++;
    end
    check(seen == 0, "R1 quiet after reset", seen, 0);

    // R9: load from idle, first tick in the 5th cycle
    {div_hi, div_lo} = 16'd5; frac_in = 4'd0; osr_sel = 2'b00;
    cfg_load = 1'b1;
    @(posedge clk); #1;
    cfg_load = 1'b0;
    for (int i = 1; i <= 5; i++) begin
      @(negedge clk);
      check(sample_tick == (i == 5), "R9 first tick from idle", int'(sample_tick), int'(i == 5));
    end

    // Vector table: R3 R4 R5 R6 R10
    for (int v = 0; v < NV; v++) begin
      int d, f, n;
      logic [1:0] m;
      d = int'(VEC[v][21:6]);
      f = int'(VEC[v][5:2]);
      m = VEC[v][1:0];
      n = ratio_of(m);
      load_cfg(d, f, m);
      measure(d, f, n, n + 16, 1'b1);
    end

    // R2: input changes without a load strobe are ignored
    load_cfg(3, 0, 2'b00);
    {div_hi, div_lo} = 16'd200; frac_in = 4'd9; osr_sel = 2'b10;
    fb = fails;
    measure(3, 0, 16, 40, 1'b0);
    check(fails == fb, "R2 inputs ignored without load", fails - fb, 0);

    // R8: reload mid-period; old period completes, then new sequence
    load_cfg(100, 0, 2'b00);
    measure(100, 0, 16, 1, 1'b0);
    begin
      int len = 0;
      do begin
        @(negedge clk);
        len++;
        if (len == 10) begin
          {div_hi, div_lo} = 16'd3; frac_in = 4'd15; osr_sel = 2'b00;
          cfg_load = 1'b1;
        end else if (len == 11) begin
          cfg_load = 1'b0;
        end
      end while (!sample_tick);
      check(len == 100, "R8 old period kept", len, 100);
    end
    // periods 3,4,... and first bit strobe on sample 16 (R3 R10)
    measure(3, 15, 16, 20, 1'b0);

    // R7: zero divisor stops everything
    load_cfg(0, 0, 2'b00);
    seen = 0;
    repeat (300) begin
      @(negedge clk);
      if (sample_tick || bit_tick) seen++;
    end
    check(seen == 0, "R7 zero divisor silent", seen, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule